// File: doc/BRIEF.md
# Queued Command Slot Scheduler

This block sits between host software and a link-layer transmit port and manages a set of tagged command slots. Software posts work by setting bits in two registers: an issue register, which requests that a slot's command frame be sent, and an active register, which reserves the slot for a queued command. The scheduler picks pending slots in rotating order. It fetches each slot's five-word command frame from a command-table RAM and streams the frame out over a valid/ready port.

Once a frame has been sent, the scheduler waits for the device's register-frame acknowledgement. That acknowledgement retires the issue bit and frees the scheduler for the next slot. The slot stays reserved after the acknowledgement. The device later names the slot it wants to serve by returning a DMA-setup event carrying the slot's tag, and it may name slots in any order. A set-device-bits event carrying a completion mask then releases the finished slots.

A mode input selects queued or non-queued operation. In queued mode a slot is sent only once it is reserved. In non-queued mode no frame goes out while any queued reservation is outstanding.

Top module: `qs_sched`

## Requirements
- R1: After reset the issue register, the active register, `tx_valid`, `tbl_rd_en` and `sel_valid` are all 0.
- R2: A write to either register sets every bit that is 1 in the written value. Bits written as 0 keep their value, and writing 1 to a bit that is already set leaves the register unchanged.
- R3: A frame for slot s is five words read from table addresses 5*s+0 through 5*s+4, sent in that order. `tx_last` is high only on the fifth word, and a word with `tx_valid` high and `tx_ready` low stays unchanged until it is accepted.
- R4: Pending slots are served in rotating order. The search starts at the slot after the last one sent, and after reset it starts at slot 0.
- R5: The issue bit of the sent slot clears on the first `rx_reg_ack` pulse after its frame's last word has been accepted. No other frame starts before that pulse, and an `rx_reg_ack` pulse with no frame awaiting acknowledgement changes nothing.
- R6: With `queued_mode`=1, a pending slot is sent only while its active bit is set.
- R7: With `queued_mode`=0, no frame starts while any active bit is set. Pending slots are sent as soon as all active bits are clear.
- R8: An `rx_dma_setup` pulse whose tag has its active bit set makes `sel_valid`=1 and `sel_tag`=tag on the next cycle, whatever order the tags arrive in. A pulse whose tag's active bit is clear is ignored.
- R9: An `rx_sdb` pulse clears, in one cycle, every active bit that is set in `rx_sdb_mask`. It also drops `sel_valid` when the mask covers `sel_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| queued_mode | input | 1 | 1 = queued commands, 0 = non-queued |
| sw_issue_we | input | 1 | Write strobe for the issue register |
| sw_issue_set | input | NSLOT | Bits to set in the issue register |
| sw_act_we | input | 1 | Write strobe for the active register |
| sw_act_set | input | NSLOT | Bits to set in the active register |
| issue_q | output | NSLOT | Issue register |
| active_q | output | NSLOT | Active (reserved) register |
| tbl_rd_en | output | 1 | Command-table read strobe |
| tbl_rd_addr | output | ADDR_W | Command-table word address |
| tbl_rd_data | input | WORD_W | Table read data, one cycle after the strobe |
| tx_valid | output | 1 | Frame word valid |
| tx_data | output | WORD_W | Frame word |
| tx_last | output | 1 | Last word of the frame |
| tx_ready | input | 1 | Link layer accepts the word |
| rx_reg_ack | input | 1 | Register-frame acknowledgement pulse |
| rx_dma_setup | input | 1 | DMA-setup frame pulse |
| rx_dma_tag | input | TAGW | Tag carried by the DMA-setup frame |
| rx_sdb | input | 1 | Set-device-bits frame pulse |
| rx_sdb_mask | input | NSLOT | Completion mask of the set-device-bits frame |
| sel_valid | output | 1 | A slot is selected for the data phase |
| sel_tag | output | TAGW | Selected slot |

## Verification
The issue path is driven with several pending patterns. The sets {0,3}, then {1} added while a frame awaits acknowledgement, then {0,5} after slot 3 was served, distinguish rotating order from fixed priority, because slot 5 must win over slot 0. The queued and non-queued modes are each given pending slots that are blocked by the state of the active register. These patterns separate the two gating rules from plain issue order. Device selections are sent out of tag order and include an unreserved tag, which shows that selection follows the device rather than the issue sequence. Frames are streamed against an irregular ready pattern, so word order, the last-word marker and table addressing are all checked under back-pressure.

// File: rtl/qs_pkg.sv
package qs_pkg;

   typedef enum logic [1:0] {
      SCH_IDLE = 2'd0,
      SCH_SEND = 2'd1,
      SCH_ACK  = 2'd2
   } sch_state_t;

   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_REQ  = 2'd1,
      RD_CAP  = 2'd2,
      RD_TX   = 2'd3
   } rd_state_t;

endpackage

// File: rtl/qs_rr_arb.sv
module qs_rr_arb #(
   parameter int NSLOT = 32,
   parameter int TAGW  = $clog2(NSLOT)
) (
   input  logic [NSLOT-1:0] req,
   input  logic [TAGW-1:0]  last,
   output logic             gnt_valid,
   output logic [TAGW-1:0]  gnt_idx
);

   localparam bit POW2 = ((NSLOT & (NSLOT - 1)) == 0);

   generate
      if (POW2) begin : g_wrap_pow2
         always_comb begin
            logic [TAGW-1:0] cand;
            gnt_valid = 1'b0;
            gnt_idx   = '0;
            for (int i = 1; i <= NSLOT; i++) begin
               cand = last + TAGW'(i);
               if (!gnt_valid && req[cand]) begin
                  gnt_valid = 1'b1;
                  gnt_idx   = cand;
               end
            end
         end
      end else begin : g_wrap_mod
         always_comb begin
            int s;
            gnt_valid = 1'b0;
            gnt_idx   = '0;
            for (int i = 1; i <= NSLOT; i++) begin
               s = int'(last) + i;
               if (s >= NSLOT) s = s - NSLOT;
               if (!gnt_valid && req[s]) begin
                  gnt_valid = 1'b1;
                  gnt_idx   = TAGW'(s);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/qs_frame_rd.sv
module qs_frame_rd
   import qs_pkg::*;
#(
   parameter int NSLOT       = 32,
   parameter int WORD_W      = 32,
   parameter int FRAME_WORDS = 5,
   parameter int TAGW        = $clog2(NSLOT),
   parameter int ADDR_W      = $clog2(NSLOT * FRAME_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TAGW-1:0]   slot,
   output logic              tbl_rd_en,
   output logic [ADDR_W-1:0] tbl_rd_addr,
   input  logic [WORD_W-1:0] tbl_rd_data,
   output logic              tx_valid,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              done
);

   localparam int IDXW = $clog2(FRAME_WORDS);
   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_WORDS - 1);

   rd_state_t         st;
   logic [TAGW-1:0]   slot_r;
   logic [IDXW-1:0]   idx;
   logic [WORD_W-1:0] hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RD_IDLE;
         slot_r <= '0;
         idx    <= '0;
         hold   <= '0;
      end else begin
         case (st)
            RD_IDLE: if (start) begin
               slot_r <= slot;
               idx    <= '0;
               st     <= RD_REQ;
            end
            RD_REQ:  st <= RD_CAP;
            RD_CAP: begin
               hold <= tbl_rd_data;
               st   <= RD_TX;
            end
            RD_TX: if (tx_ready) begin
               if (idx == LAST_IDX) begin
                  st <= RD_IDLE;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= RD_REQ;
               end
            end
            default: st <= RD_IDLE;
         endcase
      end
   end

   assign tbl_rd_en   = (st == RD_REQ);
   assign tbl_rd_addr = ADDR_W'(slot_r) * ADDR_W'(FRAME_WORDS) + ADDR_W'(idx);
   assign tx_valid    = (st == RD_TX);
   assign tx_data     = hold;
   assign tx_last     = (st == RD_TX) && (idx == LAST_IDX);
   assign done        = tx_last && tx_ready;

endmodule

// File: rtl/qs_slot_regs.sv
module qs_slot_regs #(
   parameter int NSLOT = 32,
   parameter int TAGW  = $clog2(NSLOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_issue_we,
   input  logic [NSLOT-1:0] sw_issue_set,
   input  logic             sw_act_we,
   input  logic [NSLOT-1:0] sw_act_set,
   input  logic             issue_clr_en,
   input  logic [TAGW-1:0]  issue_clr_idx,
   input  logic             sdb_en,
   input  logic [NSLOT-1:0] sdb_mask,
   input  logic             dma_en,
   input  logic [TAGW-1:0]  dma_tag,
   output logic [NSLOT-1:0] issue_q,
   output logic [NSLOT-1:0] active_q,
   output logic             sel_valid,
   output logic [TAGW-1:0]  sel_tag
);

   logic [NSLOT-1:0] clr_dec;
   logic [NSLOT-1:0] issue_set, act_set, act_clr;

   generate
      for (genvar b = 0; b < NSLOT; b++) begin : g_dec
         assign clr_dec[b] = issue_clr_en && (issue_clr_idx == TAGW'(b));
      end
   endgenerate

   assign issue_set = sw_issue_we ? sw_issue_set : '0;
   assign act_set   = sw_act_we   ? sw_act_set   : '0;
   assign act_clr   = sdb_en      ? sdb_mask     : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_q  <= '0;
         active_q <= '0;
      end else begin
         issue_q  <= (issue_q  | issue_set) & ~clr_dec;
         active_q <= (active_q | act_set)   & ~act_clr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_valid <= 1'b0;
         sel_tag   <= '0;
      end else if (dma_en && active_q[dma_tag]) begin
         sel_valid <= 1'b1;
         sel_tag   <= dma_tag;
      end else if (sdb_en && sdb_mask[sel_tag]) begin
         sel_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/qs_sched.sv
module qs_sched
   import qs_pkg::*;
#(
   parameter int NSLOT       = 32,
   parameter int WORD_W      = 32,
   parameter int FRAME_WORDS = 5,
   parameter int TAGW        = $clog2(NSLOT),
   parameter int ADDR_W      = $clog2(NSLOT * FRAME_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              queued_mode,
   input  logic              sw_issue_we,
   input  logic [NSLOT-1:0]  sw_issue_set,
   input  logic              sw_act_we,
   input  logic [NSLOT-1:0]  sw_act_set,
   output logic [NSLOT-1:0]  issue_q,
   output logic [NSLOT-1:0]  active_q,
   output logic              tbl_rd_en,
   output logic [ADDR_W-1:0] tbl_rd_addr,
   input  logic [WORD_W-1:0] tbl_rd_data,
   output logic              tx_valid,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   input  logic              rx_reg_ack,
   input  logic              rx_dma_setup,
   input  logic [TAGW-1:0]   rx_dma_tag,
   input  logic              rx_sdb,
   input  logic [NSLOT-1:0]  rx_sdb_mask,
   output logic              sel_valid,
   output logic [TAGW-1:0]   sel_tag
);

   generate
      if (NSLOT < 2 || NSLOT > 32) begin : g_bad_nslot
         $error("qs_sched: NSLOT must lie in 2..32");
      end
      if (FRAME_WORDS < 2) begin : g_bad_frame
         $error("qs_sched: FRAME_WORDS must be at least 2");
      end
      if (WORD_W < 8) begin : g_bad_word
         $error("qs_sched: WORD_W must be at least 8");
      end
   endgenerate

   sch_state_t       state;
   logic [TAGW-1:0]  cur, last_ptr;
   logic [NSLOT-1:0] eligible;
   logic             gnt_valid, start, done, clr_en;
   logic [TAGW-1:0]  gnt_idx;

   assign eligible = queued_mode ? (issue_q & active_q)
                                 : ((|active_q) ? '0 : issue_q);
   assign start    = (state == SCH_IDLE) && gnt_valid;
   assign clr_en   = (state == SCH_ACK) && rx_reg_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SCH_IDLE;
         cur      <= '0;
         last_ptr <= TAGW'(NSLOT - 1);
      end else begin
         case (state)
            SCH_IDLE: if (gnt_valid) begin
               cur      <= gnt_idx;
               last_ptr <= gnt_idx;
               state    <= SCH_SEND;
            end
            SCH_SEND: if (done)   state <= SCH_ACK;
            SCH_ACK:  if (rx_reg_ack) state <= SCH_IDLE;
            default:  state <= SCH_IDLE;
         endcase
      end
   end

   qs_rr_arb #(.NSLOT(NSLOT), .TAGW(TAGW)) u_arb (
      .req       (eligible),
      .last      (last_ptr),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   qs_frame_rd #(
      .NSLOT(NSLOT), .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS),
      .TAGW(TAGW), .ADDR_W(ADDR_W)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .slot        (gnt_idx),
      .tbl_rd_en   (tbl_rd_en),
      .tbl_rd_addr (tbl_rd_addr),
      .tbl_rd_data (tbl_rd_data),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data),
      .tx_last     (tx_last),
      .tx_ready    (tx_ready),
      .done        (done)
   );

   qs_slot_regs #(.NSLOT(NSLOT), .TAGW(TAGW)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .sw_issue_we   (sw_issue_we),
      .sw_issue_set  (sw_issue_set),
      .sw_act_we     (sw_act_we),
      .sw_act_set    (sw_act_set),
      .issue_clr_en  (clr_en),
      .issue_clr_idx (cur),
      .sdb_en        (rx_sdb),
      .sdb_mask      (rx_sdb_mask),
      .dma_en        (rx_dma_setup),
      .dma_tag       (rx_dma_tag),
      .issue_q       (issue_q),
      .active_q      (active_q),
      .sel_valid     (sel_valid),
      .sel_tag       (sel_tag)
   );

endmodule

// File: rtl/qs_sched_chk.sv
module qs_sched_chk #(
   parameter int NSLOT  = 32,
   parameter int WORD_W = 32,
   parameter int TAGW   = $clog2(NSLOT)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_issue_we,
   input logic [NSLOT-1:0]  issue_q,
   input logic [NSLOT-1:0]  active_q,
   input logic              tx_valid,
   input logic [WORD_W-1:0] tx_data,
   input logic              tx_last,
   input logic              tx_ready,
   input logic              rx_reg_ack,
   input logic              rx_sdb,
   input logic              sel_valid,
   input logic [TAGW-1:0]   sel_tag
);

   // R3
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R2
   issue_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_issue_we |=> ((issue_q & ~$past(issue_q)) == '0));

   // R5
   issue_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_reg_ack |=> (($past(issue_q) & ~issue_q) == '0));

   // R9
   active_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_sdb |=> (($past(active_q) & ~active_q) == '0));

   // R8
   sel_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> active_q[sel_tag]);

   // R3
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

endmodule

bind qs_sched qs_sched_chk #(.NSLOT(NSLOT), .WORD_W(WORD_W), .TAGW(TAGW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_issue_we (sw_issue_we),
   .issue_q     (issue_q),
   .active_q    (active_q),
   .tx_valid    (tx_valid),
   .tx_data     (tx_data),
   .tx_last     (tx_last),
   .tx_ready    (tx_ready),
   .rx_reg_ack  (rx_reg_ack),
   .rx_sdb      (rx_sdb),
   .sel_valid   (sel_valid),
   .sel_tag     (sel_tag)
);

// File: tb/qs_sched_test.sv
`timescale 1ns/1ps
module qs_sched_test;

   localparam int NSLOT  = 32;
   localparam int WORD_W = 32;
   localparam int FW     = 5;
   localparam int TAGW   = 5;
   localparam int ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              queued_mode = 1'b0;
   logic              sw_issue_we = 1'b0;
   logic [NSLOT-1:0]  sw_issue_set = '0;
   logic              sw_act_we = 1'b0;
   logic [NSLOT-1:0]  sw_act_set = '0;
   logic [NSLOT-1:0]  issue_q, active_q;
   logic              tbl_rd_en;
   logic [ADDR_W-1:0] tbl_rd_addr;
   logic [WORD_W-1:0] tbl_rd_data = '0;
   logic              tx_valid, tx_last;
   logic [WORD_W-1:0] tx_data;
   logic              tx_ready = 1'b0;
   logic              rx_reg_ack = 1'b0;
   logic              rx_dma_setup = 1'b0;
   logic [TAGW-1:0]   rx_dma_tag = '0;
   logic              rx_sdb = 1'b0;
   logic [NSLOT-1:0]  rx_sdb_mask = '0;
   logic              sel_valid;
   logic [TAGW-1:0]   sel_tag;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #10 clk = ~clk;

   function automatic logic [WORD_W-1:0] frame_word(input int s, input int k);
      return {8'hC5, 8'(s), 8'(k), 8'h3A};
   endfunction

   always_ff @(posedge clk)
      if (tbl_rd_en) tbl_rd_data <= frame_word(int'(tbl_rd_addr) / FW, int'(tbl_rd_addr) % FW);

   qs_sched uut (
      .clk(clk), .rst_n(rst_n), .queued_mode(queued_mode),
      .sw_issue_we(sw_issue_we), .sw_issue_set(sw_issue_set),
      .sw_act_we(sw_act_we), .sw_act_set(sw_act_set),
      .issue_q(issue_q), .active_q(active_q),
      .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
      .rx_reg_ack(rx_reg_ack), .rx_dma_setup(rx_dma_setup), .rx_dma_tag(rx_dma_tag),
      .rx_sdb(rx_sdb), .rx_sdb_mask(rx_sdb_mask),
      .sel_valid(sel_valid), .sel_tag(sel_tag)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit qmode);
      @(negedge clk);
      rst_n = 1'b0;
      queued_mode = qmode;
      tx_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr_issue(input logic [NSLOT-1:0] v);
      @(negedge clk);
      sw_issue_we = 1'b1; sw_issue_set = v;
      @(negedge clk);
      sw_issue_we = 1'b0; sw_issue_set = '0;
   endtask

   task automatic wr_act(input logic [NSLOT-1:0] v);
      @(negedge clk);
      sw_act_we = 1'b1; sw_act_set = v;
      @(negedge clk);
      sw_act_we = 1'b0; sw_act_set = '0;
   endtask

   task automatic pulse_ack;
      @(negedge clk);
      rx_reg_ack = 1'b1;
      @(negedge clk);
      rx_reg_ack = 1'b0;
   endtask

   task automatic pulse_dma(input int tag);
      @(negedge clk);
      rx_dma_setup = 1'b1; rx_dma_tag = TAGW'(tag);
      @(negedge clk);
      rx_dma_setup = 1'b0;
   endtask

   task automatic pulse_sdb(input logic [NSLOT-1:0] m);
      @(negedge clk);
      rx_sdb = 1'b1; rx_sdb_mask = m;
      @(negedge clk);
      rx_sdb = 1'b0; rx_sdb_mask = '0;
   endtask

   // observes that no frame starts over n cycles
   task automatic expect_quiet(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (tx_valid || tbl_rd_en) seen++;
      end
      check(seen == 0, req, 32'(seen), 32'd0);
   endtask

   // receives one frame under irregular back-pressure and compares it with slot s
   task automatic take_frame(input int s, input string req);
      int k = 0;
      int bad = 0;
      int t = 0;
      logic [31:0] first_bad = '0;
      logic [31:0] first_exp = '0;
      while (k < FW && t < 400) begin
         @(negedge clk);
         t++;
         tx_ready = ((t % 3) != 1);
         if (tx_valid && tx_ready) begin
            if (tx_data !== frame_word(s, k) || tx_last !== (k == FW - 1)) begin
               if (bad == 0) begin first_bad = tx_data; first_exp = frame_word(s, k); end
               bad++;
            end
            k++;
         end
      end
      @(negedge clk);
      tx_ready = 1'b0;
      check(k == FW && bad == 0, req, first_bad | 32'(FW - k), first_exp);
   endtask

   task automatic t_reset;
      do_reset(1'b1);
      @(negedge clk);
      check(issue_q == '0 && active_q == '0, "R1 registers", issue_q | active_q, 32'd0);
      check(!tx_valid && !tbl_rd_en && !sel_valid, "R1 outputs",
            {29'd0, tx_valid, tbl_rd_en, sel_valid}, 32'd0);
   endtask

   task automatic t_queued_gate;
      do_reset(1'b1);
      wr_issue(32'h0000_0005);
      check(issue_q == 32'h5, "R2 set", issue_q, 32'h5);
      expect_quiet(6, "R6 unreserved slots wait");
      wr_issue(32'h0000_0001);
      check(issue_q == 32'h5, "R2 rewrite set bit", issue_q, 32'h5);
      wr_issue(32'h0000_0000);
      check(issue_q == 32'h5, "R2 zero write", issue_q, 32'h5);
      wr_act(32'h0000_0004);
      check(active_q == 32'h4, "R2 active set", active_q, 32'h4);
      take_frame(2, "R3/R6 frame of reserved slot 2");
      check(issue_q == 32'h5, "R5 bit held until ack", issue_q, 32'h5);
      pulse_ack;
      check(issue_q == 32'h1, "R5 ack clears slot 2", issue_q, 32'h1);
      pulse_ack;
      check(issue_q == 32'h1, "R5 stray ack ignored", issue_q, 32'h1);
      check(active_q == 32'h4, "R5 ack keeps reservation", active_q, 32'h4);
      expect_quiet(6, "R6 slot 0 still unreserved");
      wr_act(32'h0000_0004);
      check(active_q == 32'h4, "R2 active rewrite", active_q, 32'h4);
   endtask

   task automatic t_rotate;
      do_reset(1'b0);
      wr_issue(32'h0000_0009);
      take_frame(0, "R4 first grant slot 0");
      wr_issue(32'h0000_0002);
      check(issue_q == 32'hB, "R2 set while busy", issue_q, 32'hB);
      expect_quiet(5, "R5 no frame before ack");
      pulse_ack;
      check(issue_q == 32'hA, "R5 slot 0 cleared", issue_q, 32'hA);
      take_frame(1, "R4 rotate to slot 1");
      pulse_ack;
      take_frame(3, "R4 rotate to slot 3");
      pulse_ack;
      check(issue_q == 32'h0, "R5 all retired", issue_q, 32'h0);
      wr_issue(32'h0000_0021);
      take_frame(5, "R4 slot 5 before slot 0");
      pulse_ack;
      take_frame(0, "R4 wrap to slot 0");
      pulse_ack;
      check(issue_q == 32'h0, "R5 final retire", issue_q, 32'h0);
   endtask

   task automatic t_nonqueued;
      do_reset(1'b0);
      wr_act(32'h0000_0002);
      wr_issue(32'h0000_0001);
      expect_quiet(8, "R7 blocked by reservation");
      pulse_sdb(32'h0000_0002);
      check(active_q == 32'h0, "R9 mask frees slot 1", active_q, 32'h0);
      take_frame(0, "R7 sent once free");
      pulse_ack;
      check(issue_q == 32'h0, "R5 non-queued retire", issue_q, 32'h0);
   endtask

   task automatic t_select;
      do_reset(1'b1);
      wr_act(32'hF000_0003);
      pulse_dma(31);
      check(sel_valid && sel_tag == 5'd31, "R8 select 31", {26'd0, sel_valid, sel_tag}, 32'h3F);
      pulse_dma(1);
      check(sel_valid && sel_tag == 5'd1, "R8 out of order select 1", {26'd0, sel_valid, sel_tag}, 32'h21);
      pulse_dma(5);
      check(sel_valid && sel_tag == 5'd1, "R8 unreserved tag ignored", {26'd0, sel_valid, sel_tag}, 32'h21);
      pulse_sdb(32'h0000_0002);
      check(active_q == 32'hF000_0001, "R9 clear slot 1", active_q, 32'hF000_0001);
      check(!sel_valid, "R9 selection dropped", {31'd0, sel_valid}, 32'd0);
      pulse_dma(0);
      pulse_sdb(32'h8000_0001);
      check(active_q == 32'h7000_0000, "R9 multi-bit clear", active_q, 32'h7000_0000);
      check(!sel_valid, "R9 selection 0 dropped", {31'd0, sel_valid}, 32'd0);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 20000", cyc);
         finish_run;
      end
   end

   initial begin
      t_reset;
      t_queued_gate;
      t_rotate;
      t_nonqueued;
      t_select;
      finish_run;
   end

endmodule